// File: doc/BRIEF.md
# Centronics Output Strobe Sequencer

This block moves bytes from a ready/valid byte source onto an 8-bit parallel data bus and frames each byte with a programmable data strobe. Once a byte is accepted, it is driven onto the bus. After a programmable setup time the strobe is raised for a programmable width. The byte is then finished with one of three handshakes selected by a 2-bit mode: no handshake, an acknowledge pulse from the peripheral, or the busy line used as the acknowledge.

All timing is counted in clocks of the system bus. The setup field and the width field are each 7 bits wide. The acknowledge and busy inputs come from off-chip, so each passes through a two-stage synchronizer before it is used, and edges are detected on the synchronized copies. An active busy stops a new byte from starting, and also holds back a strobe whose setup has already elapsed. The invalid mode setting raises an error flag and stops all transfers.

Top module: `cx_strobe_seq`

## Requirements
- R1: The strobe rises exactly `cfg_setup` clocks after the clock edge that puts the accepted byte on `pd_data`. The value 0 makes the byte and the strobe appear on the same edge, and 127 is the largest setup.
- R2: The strobe stays high for `cfg_width` clocks, except that width values 0, 1, 2 and 3 all give exactly 3 clocks.
- R3: With `cfg_mode` = 2'b00 (no handshake), `byte_done` pulses on the edge where the strobe falls. The next byte reaches the bus no sooner than 3 clocks after the strobe falls. With a setup of 0, a width of 3 and a source that is always valid, consecutive strobe rising edges are 6 clocks apart.
- R4: With `cfg_mode` = 2'b01 (acknowledge), the byte completes on the falling edge of `ack_in` after synchronization. `byte_done` pulses 3 clocks after the input falls at the pin, and it does not pulse before that.
- R5: With `cfg_mode` = 2'b10 (busy as acknowledge), the byte completes only after `busy_in` has risen and then fallen following the strobe. `byte_done` pulses 3 clocks after `busy_in` falls at the pin. Pulses on `ack_in` have no effect in this mode.
- R6: While the synchronized busy is high, `src_ready` stays low and no new byte starts. A strobe whose setup count has run out is also held off until busy falls.
- R7: With `cfg_mode` = 2'b11, `mode_err` is high one clock later, `src_ready` stays low and no strobe is produced. Transfers resume once a valid mode is restored.
- R8: `pd_data` carries the accepted byte and stays unchanged from acceptance until the next byte is accepted.
- R9: Reset clears `pd_data`, `pd_strobe`, `byte_done` and `mode_err`. With a valid mode and busy low, `src_ready` is high after reset.
- R10: `src_ready` is never high while the strobe is high, and `byte_done` is a single-clock pulse, given once for each byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 7 | Setup time from data to strobe, in clocks |
| cfg_width | input | 7 | Strobe width in clocks (values below 3 give 3) |
| cfg_mode | input | 2 | Handshake select {busy-as-ack, ack}; 11 is invalid |
| src_valid | input | 1 | Byte source has a byte |
| src_data | input | 8 | Byte from the source |
| src_ready | output | 1 | Sequencer accepts a byte this clock |
| ack_in | input | 1 | Asynchronous acknowledge from the peripheral |
| busy_in | input | 1 | Asynchronous busy from the peripheral |
| pd_data | output | 8 | Parallel data bus |
| pd_strobe | output | 1 | Data strobe, active high |
| byte_done | output | 1 | One-clock pulse when a byte's handshake completes |
| mode_err | output | 1 | Invalid handshake mode selected |

## Verification
The bench measures setup and strobe width in clocks for extreme values of both fields, and it checks the narrow widths that must clamp to 3 clocks. A design with an off-by-one counter would shift the strobe by one clock, and one that skipped the clamp would produce a 1-clock strobe. In the acknowledge and busy modes, the bench places the completion pulse exactly, counting both synchronizer stages. It also pulses acknowledge in busy mode, where a design that honored that pulse would finish the byte early. Further directed cases apply busy before the start and busy during setup, where a design that checked busy only at acceptance would fire the strobe into a busy peripheral. They also time the 6-clock back-to-back cycle and select the invalid mode, where a wrong design would either move a byte or fail to resume once a valid mode is restored.

// File: rtl/cx_strobe_pkg.sv
package cx_strobe_pkg;

    // Handshake selection {busy-as-ack, ack}
    localparam logic [1:0] HS_NONE = 2'b00;
    localparam logic [1:0] HS_ACK  = 2'b01;
    localparam logic [1:0] HS_BUSY = 2'b10;
    localparam logic [1:0] HS_BAD  = 2'b11;

    // Shortest strobe, and spacing after a completed byte
    localparam int unsigned MIN_STROBE = 3;
    localparam int unsigned GAP_CLKS   = 3;

    // Index of each off-chip input in the synchronizer bank
    localparam int unsigned IN_ACK  = 0;
    localparam int unsigned IN_BUSY = 1;
    localparam int unsigned IN_NUM  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT_ACK,
        ST_WAIT_BSY_HI,
        ST_WAIT_BSY_LO,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/cx_sync2.sv
module cx_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], din};
        sync_d.prev  = sync_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl  = sync_q.chain[LAST];
    assign fall = sync_q.prev & ~sync_q.chain[LAST];

endmodule

// File: rtl/cx_seq_fsm.sv
module cx_seq_fsm
    import cx_strobe_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TIME_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cfg_setup,
    input  logic [TIME_W-1:0] cfg_width,
    input  logic [1:0]        cfg_mode,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              ack_lvl,
    input  logic              ack_fall,
    input  logic              busy_lvl,
    input  logic              busy_fall,
    output logic [DATA_W-1:0] pd_data,
    output logic              pd_strobe,
    output logic              byte_done,
    output logic              mode_err
);
    localparam logic [TIME_W-1:0] MIN_W    = TIME_W'(MIN_STROBE);
    localparam logic [TIME_W-1:0] GAP_LOAD = TIME_W'(GAP_CLKS - 2);

    typedef struct packed {
        seq_state_e        state;
        logic [TIME_W-1:0] cnt;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [TIME_W-1:0] width_load;
    logic              ready_c;

    // Strobe length minus one, with the 3-clock floor applied
    always_comb begin
        if (cfg_width < MIN_W) begin
            width_load = MIN_W - 1'b1;
        end else begin
            width_load = cfg_width - 1'b1;
        end
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = (cfg_mode == HS_BAD);

        ready_c = (seq_q.state == ST_IDLE) && !busy_lvl && (cfg_mode != HS_BAD)
                  && !((cfg_mode == HS_ACK) && ack_lvl);

        unique case (seq_q.state)
            ST_IDLE: begin
                if (src_valid && ready_c) begin
                    seq_d.data = src_data;
                    if (cfg_setup == '0) begin
                        seq_d.state = ST_STROBE;
                        seq_d.cnt   = width_load;
                    end else begin
                        seq_d.state = ST_SETUP;
                        seq_d.cnt   = cfg_setup - 1'b1;
                    end
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (!busy_lvl) begin
                    seq_d.state = ST_STROBE;
                    seq_d.cnt   = width_load;
                end
            end
            ST_STROBE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (cfg_mode == HS_ACK) begin
                    seq_d.state = ST_WAIT_ACK;
                end else if (cfg_mode == HS_BUSY) begin
                    seq_d.state = ST_WAIT_BSY_HI;
                end else begin
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = GAP_LOAD;
                    seq_d.done  = 1'b1;
                end
            end
            ST_WAIT_ACK: begin
                if (ack_fall) begin
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = GAP_LOAD;
                    seq_d.done  = 1'b1;
                end
            end
            ST_WAIT_BSY_HI: begin
                if (busy_lvl) begin
                    seq_d.state = ST_WAIT_BSY_LO;
                end
            end
            ST_WAIT_BSY_LO: begin
                if (busy_fall) begin
                    seq_d.state = ST_GAP;
                    seq_d.cnt   = GAP_LOAD;
                    seq_d.done  = 1'b1;
                end
            end
            ST_GAP: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else begin
                    seq_d.state = ST_IDLE;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, data: '0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign src_ready = ready_c;
    assign pd_data   = seq_q.data;
    assign pd_strobe = (seq_q.state == ST_STROBE);
    assign byte_done = seq_q.done;
    assign mode_err  = seq_q.err;

endmodule

// File: rtl/cx_strobe_seq.sv
module cx_strobe_seq
    import cx_strobe_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TIME_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cfg_setup,
    input  logic [TIME_W-1:0] cfg_width,
    input  logic [1:0]        cfg_mode,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              ack_in,
    input  logic              busy_in,
    output logic [DATA_W-1:0] pd_data,
    output logic              pd_strobe,
    output logic              byte_done,
    output logic              mode_err
);
    logic [IN_NUM-1:0] pins;
    logic [IN_NUM-1:0] pin_lvl;
    logic [IN_NUM-1:0] pin_fall;

    assign pins[IN_ACK]  = ack_in;
    assign pins[IN_BUSY] = busy_in;

    for (genvar g = 0; g < IN_NUM; g++) begin : g_sync
        cx_sync2 #(
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pins[g]),
            .lvl   (pin_lvl[g]),
            .fall  (pin_fall[g])
        );
    end

    cx_seq_fsm #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_setup (cfg_setup),
        .cfg_width (cfg_width),
        .cfg_mode  (cfg_mode),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .ack_lvl   (pin_lvl[IN_ACK]),
        .ack_fall  (pin_fall[IN_ACK]),
        .busy_lvl  (pin_lvl[IN_BUSY]),
        .busy_fall (pin_fall[IN_BUSY]),
        .pd_data   (pd_data),
        .pd_strobe (pd_strobe),
        .byte_done (byte_done),
        .mode_err  (mode_err)
    );

endmodule

// File: rtl/cx_strobe_seq_chk.sv
module cx_strobe_seq_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TIME_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] cfg_setup,
    input logic [TIME_W-1:0] cfg_width,
    input logic [1:0]        cfg_mode,
    input logic              src_valid,
    input logic [DATA_W-1:0] src_data,
    input logic              src_ready,
    input logic              ack_in,
    input logic              busy_in,
    input logic [DATA_W-1:0] pd_data,
    input logic              pd_strobe,
    input logic              byte_done,
    input logic              mode_err
);
    // R2: a falling strobe has been high for at least three clocks
    p_strobe_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_strobe) |-> ($past(pd_strobe, 2) && $past(pd_strobe, 3)));

    // R8: the bus does not move while the strobe stays high
    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_strobe && $past(pd_strobe)) |-> $stable(pd_data));

    // R7: the invalid setting is flagged on the following clock
    p_bad_mode_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b11) |=> mode_err);

    // R10: no acceptance while the strobe is high
    p_ready_not_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !pd_strobe);

    // R10: completion is a single-clock pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R3: a new strobe never rises right after one has fallen
    p_no_quick_restrobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_strobe) |=> !pd_strobe);

endmodule

bind cx_strobe_seq cx_strobe_seq_chk #(
    .DATA_W (DATA_W),
    .TIME_W (TIME_W)
) i_chk (.*);

// File: tb/test_cx_strobe_seq.sv
`timescale 1ns/1ps
module test_cx_strobe_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_setup = '0;
    logic [6:0] cfg_width = 7'd3;
    logic [1:0] cfg_mode = 2'b00;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_ready;
    logic       ack_in = 1'b0;
    logic       busy_in = 1'b0;
    logic [7:0] pd_data;
    logic       pd_strobe;
    logic       byte_done;
    logic       mode_err;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    // {mode[23:22], setup[21:15], width[14:8], data[7:0]}
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {2'b00, 7'd0,   7'd3,   8'hA5},
        {2'b00, 7'd5,   7'd0,   8'h3C},
        {2'b00, 7'd2,   7'd7,   8'h81},
        {2'b01, 7'd0,   7'd1,   8'h5A},
        {2'b01, 7'd4,   7'd4,   8'hFF},
        {2'b10, 7'd1,   7'd2,   8'h00},
        {2'b10, 7'd3,   7'd9,   8'hC3},
        {2'b00, 7'd127, 7'd127, 8'h7E}
    };

    cx_strobe_seq i_cx_strobe_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_setup (cfg_setup),
        .cfg_width (cfg_width),
        .cfg_mode  (cfg_mode),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .ack_in    (ack_in),
        .busy_in   (busy_in),
        .pd_data   (pd_data),
        .pd_strobe (pd_strobe),
        .byte_done (byte_done),
        .mode_err  (mode_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Wait at falling edges until the byte is taken, then drop valid
    task automatic hand_over(output int t_acc);
        int c = 0;
        while (!src_ready && c < 2000) begin
            @(negedge clk);
            c++;
        end
        t_acc = cyc;
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic wait_strobe();
        int c = 0;
        while (!pd_strobe && c < 2000) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic wait_done();
        int c = 0;
        @(negedge clk);
        while (!byte_done && c < 200) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic xfer(input logic [1:0] m, input int s, input int w, input logic [7:0] d);
        int t0, t1, wid, tpin, exp_w;
        bit early;
        @(negedge clk);
        cfg_mode  = m;
        cfg_setup = 7'(s);
        cfg_width = 7'(w);
        src_valid = 1'b1;
        src_data  = d;
        hand_over(t0);
        wait_strobe();
        t1 = cyc;
        chk((t1 - t0 - 1) == s, "R1 setup clocks", t1 - t0 - 1, s);
        chk(pd_data == d, "R8 byte on bus at strobe", pd_data, d);
        wid = 0;
        while (pd_strobe && wid < 1000) begin
            wid++;
            @(negedge clk);
        end
        exp_w = (w < 3) ? 3 : w;
        chk(wid == exp_w, "R2 strobe width", wid, exp_w);
        early = 1'b0;
        if (m == 2'b00) begin
            chk(byte_done == 1'b1, "R3 done at strobe fall", byte_done, 1);
        end else if (m == 2'b01) begin
            early |= byte_done;
            repeat (2) begin @(negedge clk); early |= byte_done; end
            ack_in = 1'b1;
            repeat (3) begin @(negedge clk); early |= byte_done; end
            ack_in = 1'b0;
            tpin = cyc;
            chk(!early, "R4 no done before ack", early, 0);
            wait_done();
            chk((cyc - tpin) == 3, "R4 done after ack fall", cyc - tpin, 3);
        end else begin
            early |= byte_done;
            repeat (2) begin @(negedge clk); early |= byte_done; end
            ack_in = 1'b1;
            repeat (3) begin @(negedge clk); early |= byte_done; end
            ack_in = 1'b0;
            repeat (4) begin @(negedge clk); early |= byte_done; end
            chk(!early, "R5 ack ignored", early, 0);
            busy_in = 1'b1;
            repeat (4) begin @(negedge clk); early |= byte_done; end
            busy_in = 1'b0;
            tpin = cyc;
            chk(!early, "R5 no done while busy high", early, 0);
            wait_done();
            chk((cyc - tpin) == 3, "R5 done after busy fall", cyc - tpin, 3);
        end
        chk(pd_data == d, "R8 byte held to completion", pd_data, d);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(150000 * 20);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, t2;
        bit saw_ready, saw_strobe;

        repeat (3) @(negedge clk);
        // R9: reset values
        chk(pd_data == 8'h00, "R9 reset data", pd_data, 0);
        chk(!pd_strobe, "R9 reset strobe", pd_strobe, 0);
        chk(!byte_done, "R9 reset done", byte_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mode_err, "R9 reset error flag", mode_err, 0);
        chk(src_ready, "R9 ready after reset", src_ready, 1);

        // Table walk over setup, width and handshake modes
        for (int i = 0; i < NVEC; i++) begin
            xfer(VEC[i][23:22], int'(VEC[i][21:15]), int'(VEC[i][14:8]), VEC[i][7:0]);
        end

        // R7: invalid mode blocks transfers, then recovers
        @(negedge clk);
        cfg_mode = 2'b11; cfg_setup = 7'd0; cfg_width = 7'd3;
        src_valid = 1'b1; src_data = 8'h99;
        saw_ready = 1'b0; saw_strobe = 1'b0;
        repeat (20) begin
            @(negedge clk);
            saw_ready  |= src_ready;
            saw_strobe |= pd_strobe;
        end
        chk(mode_err, "R7 error flag", mode_err, 1);
        chk(!saw_ready, "R7 no ready", saw_ready, 0);
        chk(!saw_strobe, "R7 no strobe", saw_strobe, 0);
        cfg_mode = 2'b00;
        @(negedge clk);
        chk(!mode_err, "R7 flag clears", mode_err, 0);
        hand_over(t0);
        wait_strobe();
        chk(pd_data == 8'h99, "R7 byte after recovery", pd_data, 8'h99);
        repeat (8) @(negedge clk);

        // R6: busy before the start keeps the byte out
        busy_in = 1'b1;
        repeat (3) @(negedge clk);
        src_valid = 1'b1; src_data = 8'h11;
        saw_ready = 1'b0; saw_strobe = 1'b0;
        repeat (20) begin
            @(negedge clk);
            saw_ready  |= src_ready;
            saw_strobe |= pd_strobe;
        end
        chk(!saw_ready, "R6 no ready while busy", saw_ready, 0);
        chk(!saw_strobe, "R6 no strobe while busy", saw_strobe, 0);
        busy_in = 1'b0;
        hand_over(t0);
        wait_strobe();
        chk(pd_data == 8'h11, "R6 byte after busy", pd_data, 8'h11);
        repeat (8) @(negedge clk);

        // R6: busy rising during setup holds the strobe
        cfg_setup = 7'd10;
        src_valid = 1'b1; src_data = 8'h22;
        hand_over(t0);
        busy_in = 1'b1;
        saw_strobe = 1'b0;
        repeat (25) begin
            @(negedge clk);
            saw_strobe |= pd_strobe;
        end
        chk(!saw_strobe, "R6 strobe held in setup", saw_strobe, 0);
        chk(pd_data == 8'h22, "R8 byte held while busy", pd_data, 8'h22);
        busy_in = 1'b0;
        t1 = cyc;
        wait_strobe();
        chk((cyc - t1) == 3, "R6 strobe after busy fall", cyc - t1, 3);
        repeat (8) @(negedge clk);

        // R3: back-to-back bytes at the shortest cycle
        cfg_setup = 7'd0; cfg_width = 7'd3;
        src_valid = 1'b1; src_data = 8'h21;
        while (!src_ready) @(negedge clk);
        @(negedge clk);
        src_data = 8'h42;
        wait_strobe();
        t1 = cyc;
        while (pd_strobe) @(negedge clk);
        wait_strobe();
        t2 = cyc;
        src_valid = 1'b0;
        chk((t2 - t1) == 6, "R3 six-clock cycle", t2 - t1, 6);
        chk(pd_data == 8'h42, "R8 second byte", pd_data, 8'h42);
        repeat (10) @(negedge clk);
        chk(!pd_strobe, "R10 no extra byte", pd_strobe, 0);

        finish_run();
    end

endmodule